// File: doc/BRIEF.md
# Programmable-Phase Read Sequencer for a 16-bit DSP Host Port

This block is a bus master that performs single read transfers from an external DSP over a non-multiplexed host-port style bus, all on one bus clock. A client hands it an address through a valid/ready handshake. The block then drives chip select, the address, a read/write line held at the read level and an active-low data strobe. It walks five programmable phases and returns the sampled 16-bit word with a one-cycle done pulse.

The five phases run in a fixed order: address, data setup, data strobe, hold and recovery. Each phase length comes from a 4-bit setting, and a setting of N gives N+1 clocks. The DSP can stretch a transfer with an active-low wait input, which is first passed through a synchroniser. The wait input only holds the sequencer in the address phase or the strobe phase. The settings have enforced minimums, and these leave room for the synchroniser delay.

Top module: `dsp_rd_seq`

## Requirements
- R1: After reset `busCsN` and `busStrobeN` are high, `doneValid` is low and `reqReady` is high. `reqReady` is high only while the sequencer is idle. A request is accepted at a rising edge where `reqValid` and `reqReady` are both high.
- R2: An accepted transfer passes through the phases address, setup, strobe, hold, recovery in that order. A phase with setting N lasts N+1 clocks, and the counting starts in the cycle after the accepting edge. Chip select is low during the first four phases.
- R3: Settings below the minimums are raised to them: the address setting to at least 2, the setup setting to at least 2, the strobe setting to at least 1. With all settings zero and no wait, chip select is low for exactly 9 cycles.
- R4: `busWaitN` is synchronised by two flops. A low level sampled at edge k counts as a stall for the phase decisions at edges k+2 and k+3. The address phase and the strobe phase end only at an edge where their count has expired and no stall counts.
- R5: `busStrobeN` is low only in the strobe phase, and only while `busCsN` is low.
- R6: `busAddr` shows the accepted address from the first cycle in which `busCsN` is low, and it stays stable until `busCsN` rises.
- R7: `busData` is sampled at the edge that ends the strobe phase. `doneValid` is high for exactly the one following cycle, and `doneData` holds the sampled word during that cycle.
- R8: `busRdWrN` is high (the read level) at all times.
- R9: The settings and the address are sampled at acceptance. Changing them during a transfer does not change that transfer's timing or address.
- R10: During recovery `busCsN` is high and `reqReady` is low. With requests back to back and recovery setting R, chip select stays high for exactly R+2 cycles between transfers.
- R11: A stall that counts only during the setup or hold phase does not lengthen the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request valid |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqAddr | input | ADDR_W (24) | Read address |
| cfgAddr | input | CFG_W (4) | Address phase setting (min 2) |
| cfgSetup | input | CFG_W (4) | Data setup phase setting (min 2) |
| cfgStrobe | input | CFG_W (4) | Strobe phase setting (min 1) |
| cfgHold | input | CFG_W (4) | Hold phase setting |
| cfgRecov | input | CFG_W (4) | Recovery phase setting |
| busCsN | output | 1 | Chip select, active low |
| busRdWrN | output | 1 | Read/write line, high = read |
| busStrobeN | output | 1 | Data strobe, active low |
| busAddr | output | ADDR_W (24) | Address to the DSP |
| busData | input | DATA_W (16) | Read data from the DSP |
| busWaitN | input | 1 | DSP wait request, active low, asynchronous |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | DATA_W (16) | Captured read word |

## Verification
Chip select, the strobe and the address change one cycle after the edge that accepts a request or ends a phase, because every bus output is registered. `doneValid` rises in the cycle after the edge that ends the strobe phase. A wait level takes effect on phase decisions two and three edges after it is sampled. The bench keeps a behavioural model that advances at each rising edge from the inputs sampled there. The bench drives inputs 2 ns after the edge and compares every output against the model at the falling edge, so each result is checked in the exact cycle it is due. Directed checks also measure the chip-select low and high run lengths in cycles.

// File: rtl/dsp_rd_pkg.sv
package dsp_rd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } phase_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadAddr;
    logic captureData;
    logic csActive;
    logic strobeActive;
  } dpCtrl_t;

endpackage

// File: rtl/dsp_rd_sync.sv
module dsp_rd_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/dsp_rd_ctrl.sv
module dsp_rd_ctrl
  import dsp_rd_pkg::*;
#(
  parameter int CFG_W      = 4,
  parameter int MIN_ADDR   = 2,
  parameter int MIN_SETUP  = 2,
  parameter int MIN_STROBE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CFG_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0] cfgSetup,
  input  logic [CFG_W-1:0] cfgStrobe,
  input  logic [CFG_W-1:0] cfgHold,
  input  logic [CFG_W-1:0] cfgRecov,
  input  logic             stallSync,
  output dpCtrl_t          dpCtrl
);

  localparam logic [CFG_W-1:0] MIN_ADDR_V   = CFG_W'(MIN_ADDR);
  localparam logic [CFG_W-1:0] MIN_SETUP_V  = CFG_W'(MIN_SETUP);
  localparam logic [CFG_W-1:0] MIN_STROBE_V = CFG_W'(MIN_STROBE);

  function automatic logic [CFG_W-1:0] clampUp(input logic [CFG_W-1:0] val,
                                               input logic [CFG_W-1:0] floorVal);
    return (val < floorVal) ? floorVal : val;
  endfunction

  phase_e           phase, nxtPhase;
  logic [CFG_W-1:0] cnt, nxtCnt;
  logic [CFG_W-1:0] setupLen, strobeLen, holdLen, recovLen;
  logic             stallDly;
  logic             cntDone, holdOff, accept;

  assign cntDone  = (cnt == '0);
  // a stall blocks exit in its own cycle and in the one after release
  assign holdOff  = stallSync | stallDly;
  assign reqReady = (phase == PH_IDLE);
  assign accept   = reqReady & reqValid;

  always_comb begin
    nxtPhase            = phase;
    nxtCnt              = (cnt != '0) ? cnt - 1'b1 : cnt;
    dpCtrl.loadAddr     = 1'b0;
    dpCtrl.captureData  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        nxtCnt = cnt;
        if (accept) begin
          nxtPhase        = PH_ADDR;
          nxtCnt          = clampUp(cfgAddr, MIN_ADDR_V);
          dpCtrl.loadAddr = 1'b1;
        end
      end
      PH_ADDR: begin
        if (cntDone && !holdOff) begin
          nxtPhase = PH_SETUP;
          nxtCnt   = setupLen;
        end
      end
      PH_SETUP: begin
        if (cntDone) begin
          nxtPhase = PH_STROBE;
          nxtCnt   = strobeLen;
        end
      end
      PH_STROBE: begin
        if (cntDone && !holdOff) begin
          nxtPhase           = PH_HOLD;
          nxtCnt             = holdLen;
          dpCtrl.captureData = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cntDone) begin
          nxtPhase = PH_RECOV;
          nxtCnt   = recovLen;
        end
      end
      PH_RECOV: begin
        if (cntDone) nxtPhase = PH_IDLE;
      end
      default: nxtPhase = PH_IDLE;
    endcase
    dpCtrl.csActive     = (nxtPhase == PH_ADDR) || (nxtPhase == PH_SETUP) ||
                          (nxtPhase == PH_STROBE) || (nxtPhase == PH_HOLD);
    dpCtrl.strobeActive = (nxtPhase == PH_STROBE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      stallDly <= 1'b0;
    end else begin
      phase    <= nxtPhase;
      cnt      <= nxtCnt;
      stallDly <= stallSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupLen  <= MIN_SETUP_V;
      strobeLen <= MIN_STROBE_V;
      holdLen   <= '0;
      recovLen  <= '0;
    end else if (accept) begin
      setupLen  <= clampUp(cfgSetup, MIN_SETUP_V);
      strobeLen <= clampUp(cfgStrobe, MIN_STROBE_V);
      holdLen   <= cfgHold;
      recovLen  <= cfgRecov;
    end
  end

endmodule

// File: rtl/dsp_rd_dp.sv
module dsp_rd_dp
  import dsp_rd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] busData,
  output logic              busCsN,
  output logic              busStrobeN,
  output logic              busRdWrN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData
);

  // registered bus controls so they switch cleanly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busCsN     <= 1'b1;
      busStrobeN <= 1'b1;
      busRdWrN   <= 1'b1;
    end else begin
      busCsN     <= ~dpCtrl.csActive;
      busStrobeN <= ~dpCtrl.strobeActive;
      busRdWrN   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                busAddr <= '0;
    else if (dpCtrl.loadAddr) busAddr <= reqAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneData  <= '0;
    end else begin
      doneValid <= dpCtrl.captureData;
      if (dpCtrl.captureData) doneData <= busData;
    end
  end

endmodule

// File: rtl/dsp_rd_seq.sv
module dsp_rd_seq
  import dsp_rd_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_ADDR    = 2,
  parameter int MIN_SETUP   = 2,
  parameter int MIN_STROBE  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CFG_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]  cfgSetup,
  input  logic [CFG_W-1:0]  cfgStrobe,
  input  logic [CFG_W-1:0]  cfgHold,
  input  logic [CFG_W-1:0]  cfgRecov,
  output logic              busCsN,
  output logic              busRdWrN,
  output logic              busStrobeN,
  output logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              busWaitN,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneData
);

  logic    waitSync;
  dpCtrl_t dpCtrl;

  dsp_rd_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b1)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (busWaitN),
    .syncOut (waitSync)
  );

  dsp_rd_ctrl #(
    .CFG_W      (CFG_W),
    .MIN_ADDR   (MIN_ADDR),
    .MIN_SETUP  (MIN_SETUP),
    .MIN_STROBE (MIN_STROBE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .cfgAddr   (cfgAddr),
    .cfgSetup  (cfgSetup),
    .cfgStrobe (cfgStrobe),
    .cfgHold   (cfgHold),
    .cfgRecov  (cfgRecov),
    .stallSync (~waitSync),
    .dpCtrl    (dpCtrl)
  );

  dsp_rd_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .reqAddr    (reqAddr),
    .busData    (busData),
    .busCsN     (busCsN),
    .busStrobeN (busStrobeN),
    .busRdWrN   (busRdWrN),
    .busAddr    (busAddr),
    .doneValid  (doneValid),
    .doneData   (doneData)
  );

endmodule

// File: rtl/dsp_rd_seq_chk.sv
module dsp_rd_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              busCsN,
  input logic              busStrobeN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              doneValid
);

  assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> busCsN);

  assert_strobe_inside_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busStrobeN |-> !busCsN);

  assert_strobe_not_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCsN) |-> busStrobeN);

  assert_strobe_min_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busStrobeN) |=> !busStrobeN);

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && !$past(busCsN)) |-> $stable(busAddr));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_recov_gap_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCsN) |=> busCsN);

endmodule

bind dsp_rd_seq dsp_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqReady   (reqReady),
  .busCsN     (busCsN),
  .busStrobeN (busStrobeN),
  .busAddr    (busAddr),
  .doneValid  (doneValid)
);

// File: tb/dsp_rd_seq_tb.sv
`timescale 1ns/1ps
module dsp_rd_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [23:0] reqAddr = '0;
  logic [3:0]  cfgAddr = '0, cfgSetup = '0, cfgStrobe = '0, cfgHold = '0, cfgRecov = '0;
  logic        busCsN, busRdWrN, busStrobeN;
  logic [23:0] busAddr;
  logic [15:0] busData = 16'h1000;
  logic        busWaitN = 1'b1;
  logic        doneValid;
  logic [15:0] doneData;

  always #4 clk = ~clk;

  dsp_rd_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .cfgAddr(cfgAddr), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .cfgRecov(cfgRecov), .busCsN(busCsN), .busRdWrN(busRdWrN), .busStrobeN(busStrobeN),
    .busAddr(busAddr), .busData(busData), .busWaitN(busWaitN), .doneValid(doneValid),
    .doneData(doneData)
  );

  int    checks = 0;
  int    failures = 0;
  string curTag = "R1";

  // behavioural reference model: 0 idle,1 addr,2 setup,3 strobe,4 hold,5 recov
  int          mPhase = 0, mCnt = 0;
  int          mA, mS, mT, mH, mR;
  logic [23:0] mAddr = '0;
  logic [15:0] mData = '0;
  bit          mDone = 0, mAccept = 0;
  bit          mW1 = 1, mW2 = 1, mStallD = 0;

  function automatic int atLeast(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  always @(posedge clk) begin
    bit stallNow, exitOk;
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mDone = 0; mAccept = 0;
      mW1 = 1; mW2 = 1; mStallD = 0;
    end else begin
      stallNow = !mW2;
      exitOk   = (mCnt == 0) && !stallNow && !mStallD;
      mDone = 0; mAccept = 0;
      case (mPhase)
        0: if (reqValid) begin
             mAccept = 1;
             mA = atLeast(int'(cfgAddr), 2); mS = atLeast(int'(cfgSetup), 2);
             mT = atLeast(int'(cfgStrobe), 1); mH = int'(cfgHold); mR = int'(cfgRecov);
             mAddr = reqAddr; mPhase = 1; mCnt = mA;
           end
        1: if (exitOk) begin mPhase = 2; mCnt = mS; end else if (mCnt > 0) mCnt--;
        2: if (mCnt == 0) begin mPhase = 3; mCnt = mT; end else mCnt--;
        3: if (exitOk) begin mPhase = 4; mCnt = mH; mDone = 1; mData = busData; end
           else if (mCnt > 0) mCnt--;
        4: if (mCnt == 0) begin mPhase = 5; mCnt = mR; end else mCnt--;
        default: if (mCnt == 0) mPhase = 0; else mCnt--;
      endcase
      mStallD = stallNow; mW2 = mW1; mW1 = busWaitN;
    end
  end

  always @(posedge clk) #3 busData = busData * 16'd5 + 16'h0137;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", tag, curTag, act, exp, $time);
    end
  endtask

  int csLowRun = 0, csHighRun = 0, lastCsLen = 0, lastGap = 0;

  always @(negedge clk) begin
    if (rstN) begin
      check("R1 reqReady", 32'(reqReady), 32'(mPhase == 0));
      check("R2 busCsN", 32'(busCsN), 32'(!(mPhase >= 1 && mPhase <= 4)));
      check("R5 busStrobeN", 32'(busStrobeN), 32'(mPhase != 3));
      check("R8 busRdWrN", 32'(busRdWrN), 32'h1);
      check("R7 doneValid", 32'(doneValid), 32'(mDone));
      if (mDone) check("R7 doneData", 32'(doneData), 32'(mData));
      if (!busCsN) check("R6 busAddr", 32'(busAddr), 32'(mAddr));
      if (!busCsN) begin
        if (csHighRun > 0) lastGap = csHighRun;
        csHighRun = 0; csLowRun++;
      end else begin
        if (csLowRun > 0) lastCsLen = csLowRun;
        csLowRun = 0; csHighRun++;
      end
    end
  end

  // one read; stall window given in edges after the accepting edge
  task automatic runAccess(input logic [23:0] a, input int ca, input int cs, input int ct,
                           input int ch, input int cr, input int stallAt, input int stallLen,
                           input int expLen, input bit changeCfg);
    int cyc = 0;
    reqAddr = a; cfgAddr = 4'(ca); cfgSetup = 4'(cs); cfgStrobe = 4'(ct);
    cfgHold = 4'(ch); cfgRecov = 4'(cr); reqValid = 1'b1;
    do begin @(posedge clk); #2; end while (!mAccept);
    reqValid = 1'b0;
    if (changeCfg) begin
      reqAddr = ~a; cfgAddr = 4'hF; cfgSetup = 4'hF; cfgStrobe = 4'hF;
      cfgHold = 4'hF; cfgRecov = 4'hF;
    end
    while (mPhase != 0) begin
      busWaitN = !(cyc >= stallAt && cyc < stallAt + stallLen);
      @(posedge clk); #2; cyc++;
    end
    busWaitN = 1'b1;
    repeat (2) begin @(posedge clk); #2; end
    if (expLen >= 0) check("cs low length", 32'(lastCsLen), 32'(expLen));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curTag = "R1 reset";
    check("R1 reset busCsN", 32'(busCsN), 32'h1);
    check("R1 reset busStrobeN", 32'(busStrobeN), 32'h1);
    check("R1 reset doneValid", 32'(doneValid), 32'h0);
    check("R1 reset reqReady", 32'(reqReady), 32'h1);
    @(posedge clk); #2; rstN = 1'b1;
    repeat (3) begin @(posedge clk); #2; end

    curTag = "R2 minimum legal";
    runAccess(24'h12_3456, 2, 2, 1, 0, 0, -100, 0, 9, 0);
    curTag = "R2 long phases";
    runAccess(24'hAB_CDEF, 5, 3, 4, 2, 3, -100, 0, 18, 0);
    curTag = "R3 all zero clamp";
    runAccess(24'h00_0F0F, 0, 0, 0, 0, 0, -100, 0, 9, 0);
    curTag = "R3 setting one clamp";
    runAccess(24'h55_AA55, 1, 1, 1, 0, 1, -100, 0, 9, 0);
    curTag = "R4 stall in address phase";
    runAccess(24'h70_0001, 2, 2, 1, 1, 0, 0, 6, -1, 0);
    curTag = "R4 stall in strobe phase";
    runAccess(24'h70_0002, 2, 2, 3, 0, 1, 8, 5, -1, 0);
    curTag = "R4 late release";
    runAccess(24'h70_0003, 3, 2, 2, 0, 0, 1, 2, -1, 0);
    curTag = "R11 stall only in setup";
    runAccess(24'h70_0004, 2, 8, 1, 0, 0, 4, 1, 15, 0);
    curTag = "R11 stall only in hold";
    runAccess(24'h70_0005, 2, 2, 1, 9, 0, 10, 1, 18, 0);
    curTag = "R9 settings changed mid-access";
    runAccess(24'h3C_3C3C, 4, 2, 2, 1, 2, -100, 0, 13, 1);

    curTag = "R10 back to back";
    reqAddr = 24'h00_0100; cfgAddr = 4'd2; cfgSetup = 4'd2; cfgStrobe = 4'd1;
    cfgHold = 4'd0; cfgRecov = 4'd4; reqValid = 1'b1;
    repeat (40) begin @(posedge clk); #2; if (mAccept) reqAddr = reqAddr + 24'd3; end
    reqValid = 1'b0;
    check("R10 cs high gap", 32'(lastGap), 32'd6);
    repeat (20) begin @(posedge clk); #2; end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule